// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This block rebuilds the N, Z, V and C condition flags of a 32-bit processor after the fact. Rather than capturing the flags while an instruction executes, the pipeline saves only the result and one source operand, together with a code for the kind of operation that produced them. When the flags are needed, the saved triple is handed to this block. It recovers the missing operand arithmetically and produces the flag word.

The block also contains a wrapper for add and subtract with extend. Given two operands and the current extend flag, the wrapper computes the result. It then derives the new extend flag and evaluates the other flags with the extended rules. In this path Z can be cleared but never set, which lets multi-word arithmetic chain correctly.

Every accepted request updates a registered 5-bit flag word, so the flag word itself acts as the stored value for the next evaluation. A request with an undefined code raises an error pulse and leaves the flags unchanged.

Top module: `ccr_lazy_eval`

## Requirements
- R1: After synchronous reset, `flags_q`, `res_q`, `done_q` and `err_q` are all zero.
- R2: Flag bit positions are C=0, V=1, Z=2, N=3, X=4. Code 0 (pass-through) loads `req_res[4:0]` into `flags_q` unchanged.
- R3: For codes 1 to 8, Z is set exactly when the evaluated result is zero, and N is set when that result is negative and nonzero, so N and Z are never both set. X is kept. Code 1 (logic) clears C and V.
- R4: Code 2 (add): C = (res <u src). With a = res - src, V is set when src and res differ in sign while a has the sign of src.
- R5: Code 3 (subtract): with m = res + src, C = (m <u src) and V = bit 31 of ((m ^ res) & (m ^ src)).
- R6: Codes 4 and 5 (byte and word compare) apply the R5 rule to bits [7:0] and [15:0] only, including N and Z.
- R7: Code 6 (add with extend): C = (res <=u src). V follows R4 with a = res - src - 1.
- R8: Code 7 (subtract with extend): with m = res + src + 1, C = (m <=u src) and V follows R5 with this m.
- R9: Code 8 (shift): N and Z come from res, C = (src != 0), and V = 0.
- R10: Codes 9 (extended add) and 10 (extended subtract) treat `req_res` as op1 and `req_src` as op2. With X set, the result is op1+op2+1 or op1-op2-1 and X becomes (result <=u op2) or (op1 <=u op2); the flags follow R7 or R8. With X clear, the result is op1+op2 or op1-op2, strict less-than is used for X, and the flags follow R4 or R5. The result appears on `res_q`. For codes 0 to 8, `res_q` echoes `req_res`.
- R11: For codes 9 and 10, the new Z is the old Z ANDed with the computed Z.
- R12: Codes 11 to 15 pulse `err_q` for one cycle and leave `flags_q` and `res_q` unchanged.
- R13: Without a request, the flags are held. `done_q` is high in the cycle after each request, whatever its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Evaluation request |
| req_op | input | 4 | Operation-class code |
| req_res | input | 32 | Saved result, or op1 for codes 9 and 10 |
| req_src | input | 32 | Saved source, or op2 for codes 9 and 10 |
| flags_q | output | 5 | Registered flag word {X,N,Z,V,C} |
| res_q | output | 32 | Registered result |
| done_q | output | 1 | Request completed, one cycle after the request |
| err_q | output | 1 | Undefined code was requested |

## Verification
The flag register is the only state, so any corruption of it shows at `flags_q` one cycle after the request that caused it. It also propagates into the next extended operation through X and the sticky Z. The bench therefore checks chains of extended operations, where a wrong X or a Z that was set rather than cleared changes both `res_q` and `flags_q` on the following request. Undefined codes and idle cycles are checked by showing that `flags_q` and `res_q` hold their previous values exactly.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [3:0] {
    OP_PASS  = 4'd0,
    OP_LOGIC = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_CMPB  = 4'd4,
    OP_CMPW  = 4'd5,
    OP_ADDX  = 4'd6,
    OP_SUBX  = 4'd7,
    OP_SHIFT = 4'd8,
    OP_XADD  = 4'd9,
    OP_XSUB  = 4'd10
  } ccr_op_e;

  localparam int F_C    = 0;
  localparam int F_V    = 1;
  localparam int F_Z    = 2;
  localparam int F_N    = 3;
  localparam int F_X    = 4;
  localparam int FLAG_W = 5;
endpackage

// File: rtl/ccr_sub_rule.sv
// Subtract-style flag rule at a chosen width: the minuend is recovered as d + s.
module ccr_sub_rule #(
  parameter int W = 32
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] s,
  output logic         n,
  output logic         z,
  output logic         v,
  output logic         c
);
  logic [W-1:0] minu;

  always_comb begin
    minu = d + s;
    z    = (d == '0);
    n    = d[W-1];
    c    = (minu < s);
    v    = (minu[W-1] ^ d[W-1]) & (minu[W-1] ^ s[W-1]);
  end
endmodule

// File: rtl/ccr_class_eval.sv
// Combinational flag evaluation for classes 1..8; 'known' low for anything else.
module ccr_class_eval
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  ccr_op_e       op,
  input  logic [DW-1:0] d,
  input  logic [DW-1:0] s,
  output logic [3:0]    nzvc,
  output logic          known
);
  localparam int BW = DW / 4;
  localparam int HW = DW / 2;
  localparam int NUM_W = 3;

  logic [NUM_W-1:0] sn, sz, sv, sc;

  // Three widths of the same subtract rule: full, half-word and byte.
  generate
    for (genvar g = 0; g < NUM_W; g++) begin : g_sub
      localparam int RW = (g == 0) ? DW : ((g == 1) ? HW : BW);
      ccr_sub_rule #(.W(RW)) u_rule (
        .d (d[RW-1:0]),
        .s (s[RW-1:0]),
        .n (sn[g]),
        .z (sz[g]),
        .v (sv[g]),
        .c (sc[g])
      );
    end
  endgenerate

  logic          fz, fn;
  logic [DW-1:0] a_add, a_addx, m_subx;

  always_comb begin
    fz     = (d == '0);
    fn     = d[DW-1];
    a_add  = d - s;
    a_addx = d - s - 1'b1;
    m_subx = d + s + 1'b1;
    nzvc   = 4'b0000;
    known  = 1'b1;
    case (op)
      OP_LOGIC: nzvc = {fn, fz, 1'b0, 1'b0};
      OP_ADD:   nzvc = {fn, fz,
                        (s[DW-1] ^ d[DW-1]) & ~(a_add[DW-1] ^ s[DW-1]),
                        (d < s)};
      OP_SUB:   nzvc = {sn[0], sz[0], sv[0], sc[0]};
      OP_CMPW:  nzvc = {sn[1], sz[1], sv[1], sc[1]};
      OP_CMPB:  nzvc = {sn[2], sz[2], sv[2], sc[2]};
      OP_ADDX:  nzvc = {fn, fz,
                        (s[DW-1] ^ d[DW-1]) & ~(a_addx[DW-1] ^ s[DW-1]),
                        (d <= s)};
      OP_SUBX:  nzvc = {fn, fz,
                        (m_subx[DW-1] ^ d[DW-1]) & (m_subx[DW-1] ^ s[DW-1]),
                        (m_subx <= s)};
      OP_SHIFT: nzvc = {fn, fz, 1'b0, (s != '0)};
      default:  known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccr_ext_wrap.sv
// Extended add/subtract: result, new extend flag and the class to evaluate.
module ccr_ext_wrap
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          is_sub,
  input  logic          x_in,
  input  logic [DW-1:0] op1,
  input  logic [DW-1:0] op2,
  output logic [DW-1:0] res,
  output logic          x_out,
  output ccr_op_e       cls
);
  always_comb begin
    if (is_sub) begin
      res   = op1 - op2 - {{(DW-1){1'b0}}, x_in};
      x_out = x_in ? (op1 <= op2) : (op1 < op2);
      cls   = x_in ? OP_SUBX : OP_SUB;
    end else begin
      res   = op1 + op2 + {{(DW-1){1'b0}}, x_in};
      x_out = x_in ? (res <= op2) : (res < op2);
      cls   = x_in ? OP_ADDX : OP_ADD;
    end
  end
endmodule

// File: rtl/ccr_lazy_eval.sv
module ccr_lazy_eval
  import ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [DW-1:0]     req_res,
  input  logic [DW-1:0]     req_src,
  output logic [FLAG_W-1:0] flags_q,
  output logic [DW-1:0]     res_q,
  output logic              done_q,
  output logic              err_q
);
  ccr_op_e       op_in;
  logic          is_ext;
  logic [DW-1:0] w_res;
  logic          w_x;
  ccr_op_e       w_cls;
  ccr_op_e       ev_op;
  logic [DW-1:0] ev_d;
  logic [3:0]    ev_nzvc;
  logic          ev_known;
  logic          known;
  logic [FLAG_W-1:0] flags_nxt;
  logic [DW-1:0]     res_nxt;

  assign op_in  = ccr_op_e'(req_op);
  assign is_ext = (op_in == OP_XADD) || (op_in == OP_XSUB);

  ccr_ext_wrap #(.DW(DW)) u_wrap (
    .is_sub (op_in == OP_XSUB),
    .x_in   (flags_q[F_X]),
    .op1    (req_res),
    .op2    (req_src),
    .res    (w_res),
    .x_out  (w_x),
    .cls    (w_cls)
  );

  assign ev_op = is_ext ? w_cls : op_in;
  assign ev_d  = is_ext ? w_res : req_res;

  ccr_class_eval #(.DW(DW)) u_eval (
    .op    (ev_op),
    .d     (ev_d),
    .s     (req_src),
    .nzvc  (ev_nzvc),
    .known (ev_known)
  );

  always_comb begin
    known     = ev_known || (op_in == OP_PASS);
    res_nxt   = ev_d;
    flags_nxt = {flags_q[F_X], ev_nzvc};
    if (op_in == OP_PASS) begin
      flags_nxt = req_res[FLAG_W-1:0];
    end else if (is_ext) begin
      flags_nxt[F_X] = w_x;
      flags_nxt[F_Z] = ev_nzvc[F_Z] & flags_q[F_Z];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= req_valid;
      err_q  <= req_valid && !known;
      if (req_valid && known) begin
        flags_q <= flags_nxt;
        res_q   <= res_nxt;
      end
    end
  end
endmodule

// File: rtl/ccr_lazy_eval_chk.sv
module ccr_lazy_eval_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [3:0]  req_op,
  input logic [31:0] req_res,
  input logic [4:0]  flags_q,
  input logic [31:0] res_q,
  input logic        done_q,
  input logic        err_q
);
  p_pass_load_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd0) |=> (flags_q == $past(req_res[4:0])));

  p_nz_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op >= 4'd1 && req_op <= 4'd8) |=> !(flags_q[3] && flags_q[2]));

  p_x_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op >= 4'd1 && req_op <= 4'd8) |=> (flags_q[4] == $past(flags_q[4])));

  p_logic_cv_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd1) |=> (flags_q[1:0] == 2'b00));

  p_shift_v_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 4'd8) |=> !flags_q[1]);

  p_z_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 4'd9 || req_op == 4'd10) && !flags_q[2]) |=> !flags_q[2]);

  p_bad_op_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op > 4'd10) |=> (err_q && $stable(flags_q) && $stable(res_q)));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(flags_q) && !err_q && !done_q));

  p_done_r13: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_q);
endmodule

bind ccr_lazy_eval ccr_lazy_eval_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_res   (req_res),
  .flags_q   (flags_q),
  .res_q     (res_q),
  .done_q    (done_q),
  .err_q     (err_q)
);

// File: tb/ccr_lazy_eval_test.sv
`timescale 1ns/1ps
module ccr_lazy_eval_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [31:0] req_res, req_src;
  logic [4:0]  flags_q;
  logic [31:0] res_q;
  logic        done_q, err_q;

  int checks = 0;
  int fails  = 0;
  logic [4:0]  mflags;   // bench model of the flag word
  logic [31:0] mres;

  always #2.5 clk = ~clk;

  ccr_lazy_eval uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_res(req_res), .req_src(req_src), .flags_q(flags_q),
    .res_q(res_q), .done_q(done_q), .err_q(err_q)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of the N/Z/V/C nibble as the requirements describe it, at width w.
  function automatic logic [3:0] nz_of(input logic [31:0] r, input int w);
    logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    logic zz = ((r & mask) == 0);
    logic nn = r[w-1] && !zz;
    return {nn, zz, 2'b00};
  endfunction

  function automatic logic [3:0] model_sub(input logic [31:0] r, input logic [31:0] s,
                                           input int w, input logic plus1);
    logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    logic [31:0] m = (r + s + {31'd0, plus1}) & mask;
    logic [31:0] sm = s & mask;
    logic [31:0] rm = r & mask;
    logic cc = plus1 ? (m <= sm) : (m < sm);
    logic vv = (m[w-1] != sm[w-1]) && (m[w-1] != rm[w-1]);
    return nz_of(r, w) | {2'b00, vv, cc};
  endfunction

  function automatic logic [3:0] model_add(input logic [31:0] r, input logic [31:0] s,
                                           input logic plus1);
    logic [31:0] a = r - s - {31'd0, plus1};
    logic cc = plus1 ? (r <= s) : (r < s);
    logic vv = (s[31] != r[31]) && (a[31] == s[31]);
    return nz_of(r, 32) | {2'b00, vv, cc};
  endfunction

  // Apply one request to the bench model.
  task automatic model_step(input logic [3:0] op, input logic [31:0] r, input logic [31:0] s);
    logic [3:0] f;
    logic xo;
    logic [31:0] rr;
    case (op)
      4'd0: begin mflags = r[4:0]; mres = r; end
      4'd1: begin mflags = {mflags[4], nz_of(r, 32)}; mres = r; end
      4'd2: begin mflags = {mflags[4], model_add(r, s, 1'b0)}; mres = r; end
      4'd3: begin mflags = {mflags[4], model_sub(r, s, 32, 1'b0)}; mres = r; end
      4'd4: begin mflags = {mflags[4], model_sub(r, s, 8, 1'b0)}; mres = r; end
      4'd5: begin mflags = {mflags[4], model_sub(r, s, 16, 1'b0)}; mres = r; end
      4'd6: begin mflags = {mflags[4], model_add(r, s, 1'b1)}; mres = r; end
      4'd7: begin mflags = {mflags[4], model_sub(r, s, 32, 1'b1)}; mres = r; end
      4'd8: begin mflags = {mflags[4], nz_of(r, 32) | {3'b000, (s != 0)}}; mres = r; end
      4'd9: begin
        rr = r + s + {31'd0, mflags[4]};
        xo = mflags[4] ? (rr <= s) : (rr < s);
        f  = model_add(rr, s, mflags[4]);
        mflags = {xo, f[3], f[2] & mflags[2], f[1:0]};
        mres = rr;
      end
      4'd10: begin
        rr = r - s - {31'd0, mflags[4]};
        xo = mflags[4] ? (r <= s) : (r < s);
        f  = model_sub(rr, s, 32, mflags[4]);
        mflags = {xo, f[3], f[2] & mflags[2], f[1:0]};
        mres = rr;
      end
      default: ;
    endcase
  endtask

  // Drive one request at a falling edge; outputs are registered at the next
  // rising edge and sampled at the falling edge after it.
  task automatic issue(input logic [3:0] op, input logic [31:0] r, input logic [31:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_res = r; req_src = s;
    @(negedge clk);
    req_valid = 1'b0;
    model_step(op, r, s);
  endtask

  task automatic run_one(input string req, input logic [3:0] op,
                         input logic [31:0] r, input logic [31:0] s);
    issue(op, r, s);
    chk(req, {59'd0, flags_q}, {59'd0, mflags});
    chk({req, " res"}, {32'd0, res_q}, {32'd0, mres});
    chk("R13 done", {63'd0, done_q}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 flags", {59'd0, flags_q}, 64'd0);
    chk("R1 res",   {32'd0, res_q},   64'd0);
    chk("R1 done",  {63'd0, done_q},  64'd0);
    chk("R1 err",   {63'd0, err_q},   64'd0);
  endtask

  task automatic t_pass;
    issue(4'd0, 32'h0000_001A, 32'h0);
    chk("R2 pass load", {59'd0, flags_q}, 64'h1A);
    run_one("R2 pass", 4'd0, 32'hFFFF_FFE5, 32'h0);
  endtask

  task automatic t_logic;
    issue(4'd0, 32'h0000_0013, 32'h0);  // X, C, V set beforehand
    issue(4'd1, 32'h0, 32'h0);
    chk("R3 logic zero", {59'd0, flags_q}, 64'h14);
    issue(4'd1, 32'h8000_0000, 32'h0);
    chk("R3 logic neg", {59'd0, flags_q}, 64'h18);
    run_one("R3 logic pos", 4'd1, 32'h0000_0001, 32'h0);
  endtask

  task automatic t_add;
    issue(4'd2, 32'h0, 32'h1);
    chk("R4 add carry zero", {59'd0, flags_q}, {59'd0, mflags[4], 4'b0101});
    issue(4'd2, 32'h8000_0000, 32'h1);
    chk("R4 add overflow", {59'd0, flags_q}, {59'd0, mflags[4], 4'b1010});
    run_one("R4 add plain", 4'd2, 32'h0000_0005, 32'h0000_0003);
  endtask

  task automatic t_sub;
    issue(4'd3, 32'hFFFF_FFFF, 32'h1);  // 0 - 1
    chk("R5 sub borrow", {59'd0, flags_q}, {59'd0, mflags[4], 4'b1001});
    issue(4'd3, 32'h7FFF_FFFF, 32'h1);  // 0x80000000 - 1
    chk("R5 sub overflow", {59'd0, flags_q}, {59'd0, mflags[4], 4'b0010});
    run_one("R5 sub", 4'd3, 32'h1234_5678, 32'h0F0F_0F0F);
  endtask

  task automatic t_cmp;
    issue(4'd4, 32'hFFFF_FF00, 32'h0000_0005);
    chk("R6 cmpb low zero", {59'd0, flags_q}, {59'd0, mflags[4], 4'b0100});
    run_one("R6 cmpb", 4'd4, 32'h0000_00FF, 32'h0000_0001);
    run_one("R6 cmpw", 4'd5, 32'h0001_8000, 32'h0000_0001);
    run_one("R6 cmpw zero", 4'd5, 32'hABCD_0000, 32'h0000_1234);
  endtask

  task automatic t_extended_rules;
    issue(4'd6, 32'h0000_0007, 32'h0000_0007);
    chk("R7 addx equal carry", {59'd0, flags_q[0]}, 64'd1);
    run_one("R7 addx", 4'd6, 32'h8000_0000, 32'h0000_0001);
    issue(4'd7, 32'hFFFF_FFFE, 32'h0000_0001);  // minuend 0
    chk("R8 subx carry", {59'd0, flags_q[0]}, 64'd1);
    run_one("R8 subx", 4'd7, 32'h7FFF_FFFE, 32'h0000_0001);
  endtask

  task automatic t_shift;
    issue(4'd8, 32'h8000_0000, 32'h0000_0001);
    chk("R9 shift carry", {59'd0, flags_q[3:0]}, 64'b1001);
    run_one("R9 shift no carry", 4'd8, 32'h0, 32'h0);
  endtask

  task automatic t_wrapper;
    issue(4'd0, 32'h0000_0014, 32'h0);  // X=1, Z=1
    issue(4'd9, 32'hFFFF_FFFF, 32'h0);  // sum with X = 0
    chk("R10 xadd res", {32'd0, res_q}, 64'h0);
    chk("R10 xadd x", {63'd0, flags_q[4]}, 64'd1);
    chk("R11 xadd z kept", {63'd0, flags_q[2]}, 64'd1);
    run_one("R10 xadd nz", 4'd9, 32'h1, 32'h1);     // 3, X clears
    issue(4'd9, 32'h0, 32'h0);                      // zero result, Z stays clear
    chk("R11 z sticky", {63'd0, flags_q[2]}, 64'd0);
    chk("R10 xadd zero res", {32'd0, res_q}, 64'h0);
    run_one("R10 xsub borrow", 4'd10, 32'h0, 32'h1);
    run_one("R10 xsub with x", 4'd10, 32'h5, 32'h5);
    issue(4'd0, 32'h0000_0004, 32'h0);
    run_one("R11 xsub zero keeps z", 4'd10, 32'h9, 32'h9);
  endtask

  task automatic t_bad_and_idle;
    logic [4:0]  f0;
    logic [31:0] r0;
    issue(4'd0, 32'h0000_000B, 32'h0);
    f0 = flags_q; r0 = res_q;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'd13; req_res = 32'h0; req_src = 32'h5;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 err pulse", {63'd0, err_q}, 64'd1);
    chk("R12 flags held", {59'd0, flags_q}, {59'd0, f0});
    chk("R12 res held", {32'd0, res_q}, {32'd0, r0});
    @(negedge clk);
    chk("R12 err one cycle", {63'd0, err_q}, 64'd0);
    chk("R13 idle flags", {59'd0, flags_q}, {59'd0, f0});
    chk("R13 idle done low", {63'd0, done_q}, 64'd0);
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 4'd0; req_res = '0; req_src = '0;
    mflags = '0; mres = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_pass;
    t_logic;
    t_add;
    t_sub;
    t_cmp;
    t_extended_rules;
    t_shift;
    t_wrapper;
    t_bad_and_idle;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule